// File: doc/BRIEF.md
# Interrupt and Exception Control Registers

This block sits beside a processor pipeline and holds the state that governs interrupts and exceptions. It holds a status word, a cause word, an exception return address and a faulting-address register. Five hardware request lines are sampled into per-level pending bits. Each pending bit is gated by its own mask bit and by one global enable. The result drives a registered interrupt request toward the pipeline, which takes it at an instruction boundary of its own choosing.

The block also keeps a three-deep stack of mode/enable pairs. Each pair holds a user/kernel bit (bit 1, 1 means user) and an interrupt-enable bit (bit 0, 1 means interrupts allowed). Taking an exception pushes the stack and drops the processor into kernel mode with interrupts off. Returning from the exception pops the stack. Software reaches the registers through a read port and a write port, both addressed by register number: 8 is the faulting address, 12 is status, 13 is cause, and 14 is the exception PC.

Top module: `exc_ctrl_top`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 read zero and `irq_o` is low.
- R2: Cause bits [14:10] show request lines 0..4 one clock after they are sampled. A bit stays set for as long as its line is high and clears once the line drops, whatever the mask and enable are. Cause bit 15 always reads zero.
- R3: `irq_o` goes high one clock after status bit 0 is 1 while some pending bit has its mask bit (status bit 10+n for level n) set. Because it is registered, it stays high in the cycle that follows an exception.
- R4: `irq_o` is low one clock after the global enable is 0 or after no pending level is masked in.
- R5: An exception strobe moves status [3:2] into [5:4] and [1:0] into [3:2], and sets [1:0] to 00 (kernel mode, interrupts off).
- R6: An exception strobe loads register 14 with the faulting PC, register 8 with the faulting address, and cause bits [6:2] with the exception code. All take effect by the next cycle.
- R7: A return strobe moves status [3:2] into [1:0] and [5:4] into [3:2], and leaves [5:4] unchanged.
- R8: A software write to status updates bits [5:0] and [14:10] by the next cycle. All other status bits read zero regardless of the written data.
- R9: Software writes to register 13 have no effect on the cause value.
- R10: When an exception strobe coincides with a return strobe or with a status write, only the exception entry takes effect.
- R11: Registers 8 and 14 accept software writes. Any register number other than 8, 12, 13 and 14 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_LVL | Hardware interrupt request lines, one per level |
| exc_take_i | input | 1 | Exception-taken strobe |
| exc_code_i | input | CODE_W | Exception type code |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| exc_badva_i | input | XLEN | Faulting virtual address |
| eret_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Software register write enable |
| wr_addr_i | input | 5 | Register number for a write |
| wr_data_i | input | XLEN | Write data |
| rd_addr_i | input | 5 | Register number for a read |
| rd_data_o | output | XLEN | Read data (combinational) |
| irq_o | output | 1 | Registered interrupt request to the pipeline |

## Verification
On every cycle, the embedded assertions check the following: the stack shifts on exception entry and on return, the current pair is forced to 00 on entry, the exception PC is captured, and the request is suppressed after the enable is cleared. The ignored fields of status writes, the read-only cause register and the zero read of unmapped numbers can only be shown by the bench's scenarios. The same holds for the exact latency from a request line to `irq_o` and for the outcome when the three strobes collide.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int STACK_W  = 6;
  localparam int MASK_LSB = 10;
  localparam int PEND_LSB = 10;
  localparam int CODE_LSB = 2;
  localparam int REG_BADVA = 8;
  localparam int REG_STAT  = 12;
  localparam int REG_CAUSE = 13;
  localparam int REG_EPC   = 14;

  // Entry: each pair moves up one slot, current becomes kernel with IE off.
  function automatic logic [STACK_W-1:0] stack_push(input logic [STACK_W-1:0] s);
    return {s[3:0], 2'b00};
  endfunction

  // Return: each pair moves down one slot, the oldest pair is kept.
  function automatic logic [STACK_W-1:0] stack_pop(input logic [STACK_W-1:0] s);
    return {s[5:4], s[5:2]};
  endfunction
endpackage

// File: rtl/irq_mode_stack.sv
module irq_mode_stack
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               sw_we_i,
  input  logic [STACK_W-1:0] sw_val_i,
  output logic [STACK_W-1:0] stack_o
);
  logic [STACK_W-1:0] stack_q;
  logic [STACK_W-1:0] stack_d;

  always_comb begin
    stack_d = stack_q;
    if (push_i)       stack_d = stack_push(stack_q);
    else if (pop_i)   stack_d = stack_pop(stack_q);
    else if (sw_we_i) stack_d = sw_val_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stack_q <= '0;
    else        stack_q <= stack_d;
  end

  assign stack_o = stack_q;

  // R5
  entry_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (stack_q[1:0] == 2'b00));
  // R5
  entry_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (stack_q[3:2] == $past(stack_q[1:0]) && stack_q[5:4] == $past(stack_q[3:2])));
  // R7
  return_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (stack_q[5:4] == $past(stack_q[5:4]) &&
                            stack_q[3:2] == $past(stack_q[5:4]) &&
                            stack_q[1:0] == $past(stack_q[3:2])));
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_LVL = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  output logic [NUM_LVL-1:0] pend_o
);
  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    logic seen_q;
    always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= req_i[lv];
    end
    assign pend_o[lv] = seen_q;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_LVL = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ie_i,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] mask_i,
  output logic               irq_o
);
  function automatic logic should_fire(input logic ie,
                                       input logic [NUM_LVL-1:0] p,
                                       input logic [NUM_LVL-1:0] m);
    return ie && (|(p & m));
  endfunction

  logic fire_now;
  logic irq_q;

  assign fire_now = should_fire(ie_i, pend_i, mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire_now;
  end

  assign irq_o = irq_q;

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |=> !irq_o);
  // R4
  unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/exc_ctrl_top.sv
module exc_ctrl_top
  import irq_ctl_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_LVL = 5,
  parameter int CODE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_req_i,
  input  logic               exc_take_i,
  input  logic [CODE_W-1:0]  exc_code_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic [XLEN-1:0]    exc_badva_i,
  input  logic               eret_i,
  input  logic               wr_en_i,
  input  logic [4:0]         wr_addr_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic [4:0]         rd_addr_i,
  output logic [XLEN-1:0]    rd_data_o,
  output logic               irq_o
);
  localparam logic [4:0] A_BADVA = 5'(REG_BADVA);
  localparam logic [4:0] A_STAT  = 5'(REG_STAT);
  localparam logic [4:0] A_CAUSE = 5'(REG_CAUSE);
  localparam logic [4:0] A_EPC   = 5'(REG_EPC);

  // named events for assertions
  logic stat_wr;
  logic sw_stat_wr;
  logic epc_wr;
  logic badva_wr;

  assign stat_wr    = wr_en_i && (wr_addr_i == A_STAT);
  assign sw_stat_wr = stat_wr && !exc_take_i;
  assign epc_wr     = wr_en_i && (wr_addr_i == A_EPC);
  assign badva_wr   = wr_en_i && (wr_addr_i == A_BADVA);

  logic [STACK_W-1:0] stack;
  logic [NUM_LVL-1:0] pend;
  logic [NUM_LVL-1:0] mask_q;
  logic [CODE_W-1:0]  code_q;
  logic [XLEN-1:0]    epc_q;
  logic [XLEN-1:0]    badva_q;

  irq_mode_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (exc_take_i),
    .pop_i    (eret_i),
    .sw_we_i  (sw_stat_wr),
    .sw_val_i (wr_data_i[STACK_W-1:0]),
    .stack_o  (stack)
  );

  irq_pend_latch #(.NUM_LVL(NUM_LVL)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_req_i),
    .pend_o (pend)
  );

  irq_gate #(.NUM_LVL(NUM_LVL)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .ie_i   (stack[0]),
    .pend_i (pend),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      code_q  <= '0;
      epc_q   <= '0;
      badva_q <= '0;
    end else begin
      if (sw_stat_wr) mask_q <= wr_data_i[MASK_LSB +: NUM_LVL];
      if (exc_take_i) begin
        code_q  <= exc_code_i;
        epc_q   <= exc_pc_i;
        badva_q <= exc_badva_i;
      end else begin
        if (epc_wr)   epc_q   <= wr_data_i;
        if (badva_wr) badva_q <= wr_data_i;
      end
    end
  end

  logic [XLEN-1:0] stat_word;
  logic [XLEN-1:0] cause_word;

  always_comb begin
    stat_word = '0;
    stat_word[STACK_W-1:0] = stack;
    stat_word[MASK_LSB +: NUM_LVL] = mask_q;
    cause_word = '0;
    cause_word[PEND_LSB +: NUM_LVL] = pend;
    cause_word[CODE_LSB +: CODE_W] = code_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_STAT)       rd_data_o = stat_word;
    else if (rd_addr_i == A_CAUSE) rd_data_o = cause_word;
    else if (rd_addr_i == A_EPC)   rd_data_o = epc_q;
    else if (rd_addr_i == A_BADVA) rd_data_o = badva_q;
  end

  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_i |=> (epc_q == $past(exc_pc_i)));
  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(stack[0]));
  // R10
  entry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take_i && (eret_i || stat_wr)) |=> (stack[1:0] == 2'b00));
endmodule

// File: tb/test_exc_ctrl_top.sv
module test_exc_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_req_i = '0;
  logic        exc_take_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic [31:0] exc_pc_i = '0;
  logic [31:0] exc_badva_i = '0;
  logic        eret_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  always #5 clk = ~clk;

  exc_ctrl_top i_exc_ctrl_top (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .exc_take_i(exc_take_i),
    .exc_code_i(exc_code_i), .exc_pc_i(exc_pc_i), .exc_badva_i(exc_badva_i),
    .eret_i(eret_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected-value helpers written from the requirements
  function automatic logic [31:0] st(input logic [4:0] m, input logic [5:0] s);
    return (32'(m) << 10) | 32'(s);
  endfunction
  function automatic logic [31:0] ca(input logic [4:0] p, input logic [4:0] c);
    return (32'(p) << 10) | (32'(c) << 2);
  endfunction

  // monitor: compares queued expectations away from the clock edge
  always begin
    @(negedge clk);
    #3;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rd_data_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
    rd_addr_i = a;
    #1 sb.push_back('{1'b0, e, tag});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1 sb.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic take(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] va);
    exc_take_i = 1'b1; exc_code_i = c; exc_pc_i = pc; exc_badva_i = va;
    @(negedge clk);
    exc_take_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_reg(5'd12, 32'h0, "R1 status");
    chk_reg(5'd13, 32'h0, "R1 cause");
    chk_reg(5'd14, 32'h0, "R1 epc");
    chk_reg(5'd8,  32'h0, "R1 badva");
    chk_irq(1'b0, "R1 irq");

    // R2 pending latched while disabled and masked
    irq_req_i = 5'b00101;
    @(negedge clk);
    chk_reg(5'd13, ca(5'b00101, 5'd0), "R2 pending set");
    chk_irq(1'b0, "R4 irq off while IE=0");

    // R8 status write, ignored bits; R3 irq rises one cycle later
    wr(5'd12, st(5'b00100, 6'b000001) | 32'h0010_8100);
    chk_reg(5'd12, st(5'b00100, 6'b000001), "R8 status write");
    chk_irq(1'b1, "R3 irq asserted");

    // R4 mask selects a level that is not pending
    wr(5'd12, st(5'b00010, 6'b000001));
    @(negedge clk);
    chk_irq(1'b0, "R4 masked out");

    // load a full stack with user mode
    wr(5'd12, st(5'b00100, 6'b100111));
    @(negedge clk);
    chk_irq(1'b1, "R3 irq with user mode");

    // R5 R6 exception entry
    take(5'd9, 32'h8000_0180, 32'h0000_1234);
    chk_irq(1'b1, "R3 registered irq still high");
    chk_irq(1'b0, "R4 irq off after entry");
    chk_reg(5'd12, st(5'b00100, 6'b011100), "R5 stack push");
    chk_reg(5'd13, ca(5'b00101, 5'd9), "R6 code");
    chk_reg(5'd14, 32'h8000_0180, "R6 epc");
    chk_reg(5'd8,  32'h0000_1234, "R6 badva");

    // R7 return
    eret_i = 1'b1;
    @(negedge clk);
    eret_i = 1'b0;
    chk_reg(5'd12, st(5'b00100, 6'b010111), "R7 stack pop");

    // R9 cause is read-only
    wr(5'd13, 32'hFFFF_FFFF);
    chk_reg(5'd13, ca(5'b00101, 5'd9), "R9 cause write ignored");

    // R10 collision: entry wins over return and status write
    exc_take_i = 1'b1; exc_code_i = 5'd3; exc_pc_i = 32'h40; exc_badva_i = 32'h55;
    eret_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 5'd12; wr_data_i = 32'h3;
    @(negedge clk);
    exc_take_i = 1'b0; eret_i = 1'b0; wr_en_i = 1'b0;
    chk_reg(5'd12, st(5'b00100, 6'b011100), "R10 status");
    chk_reg(5'd13, ca(5'b00101, 5'd3), "R10 cause");
    chk_reg(5'd14, 32'h40, "R10 epc");

    // R11 software-writable address registers and unmapped numbers
    wr(5'd14, 32'hABCD_0004);
    chk_reg(5'd14, 32'hABCD_0004, "R11 epc write");
    wr(5'd8, 32'h0F0F_0F0F);
    chk_reg(5'd8, 32'h0F0F_0F0F, "R11 badva write");
    chk_reg(5'd3,  32'h0, "R11 unmapped 3");
    chk_reg(5'd15, 32'h0, "R11 unmapped 15");

    // R2 pending clears after the lines drop
    irq_req_i = 5'b00000;
    @(negedge clk);
    chk_reg(5'd13, ca(5'b00000, 5'd3), "R2 pending cleared");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule